// File: doc/BRIEF.md
# Triple-DES EDE Sequencing Controller

This block drives a three-pass Feistel cipher engine in encrypt-decrypt-encrypt order. One 32-bit input bus carries the text block and the keys. The host presents the 64-bit text block and the first key, two words each with the high word first. While the passes run, the block raises a one-cycle key request. The host answers with the next key in the following two cycles. Each 64-bit result leaves on a 32-bit output over two cycles, marked by a valid flag. One operation, from the accepting clock edge to the last result word, takes 54 cycles.

Inside, a key-schedule unit turns each 64-bit key into sixteen 32-bit round subkeys. In the decryption direction it produces them in reverse order. A combinational round unit performs one Feistel round per cycle on a 64-bit text register. The output of each pass stays in that register and becomes the input of the next pass. A mode bit, captured when an operation starts, selects whether the three passes run as E-D-E or D-E-D. For D-E-D the host supplies the keys in reverse order (third key first), so decrypting with the keys in that order undoes an encryption.

States: IDLE (waiting for start), LOAD (three cycles taking the text low word and the first key), RUN (48 round cycles, three passes of 16), OUT_HI and OUT_LO (the two result words). Transitions: IDLE to LOAD when start is high. LOAD to RUN after the third load cycle. RUN to OUT_HI after round 16 of pass 3. OUT_HI to OUT_LO to IDLE unconditionally. Reset returns the block to IDLE from any state.

Top module: `tdes_ede_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it is released, dout is zero and dout_valid and key_req are low. Reset is synchronous and active high, and it abandons an operation in progress.
- R2: Start is accepted only in IDLE. The rising edge that accepts it is edge 1, and it takes din as the text high word. Edge 2 takes the text low word. Edges 3 and 4 take the first key, high word then low word.
- R3: The decrypt input is sampled only on edge 1: 0 selects pass directions E,D,E and 1 selects D,E,D.
- R4: key_req is high for exactly one cycle after edge 4 and one cycle after edge 20. The second key is taken from din on edges 6 (high) and 7 (low). The third key is taken on edges 22 (high) and 23 (low). din is ignored on all other edges.
- R5: In encrypt mode the result equals pass E with key 1, then pass D with key 2, then pass E with key 3. Each pass takes the full 64-bit output of the pass before it.
- R6: In decrypt mode the passes run D, E, D with the keys in the order they are presented. Decrypting an encrypt result with the keys presented in reverse order returns the original text.
- R7: Key schedule. Bits 8n+7..8n+1 of each byte n of the key form 56 bits, low byte lowest. C is the upper 28 bits and D is the lower 28. Before encrypt round j (0..15), C and D each rotate left by 1 when j is 0, 1, 8 or 15, and by 2 otherwise. Subkey = {C[27:12],D[15:0]} XOR {D[27:16],C[11:0],8'h00}. A D pass uses the encrypt subkeys in reverse round order.
- R8: A pass has 16 rounds on halves L (bits 63:32) and R. Each round sets L'=R and R'=L^F(R,K). Here t=R^K and F = rotl(t,3) XOR (t + 32'h9E3779B9). After round 16 the halves are swapped, giving output {R16,L16}.
- R9: dout_valid is high exactly in the cycles after edges 52 and 53. dout carries the result high word and then the low word. dout is zero whenever dout_valid is low.
- R10: A start while an operation is in progress has no effect on its result, its timing or its mode.
- R11: A start presented in the cycle right after the low result word is accepted. Back-to-back operations are independent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an operation (honoured in IDLE only) |
| decrypt | input | 1 | Mode captured at start: 0 E-D-E, 1 D-E-D |
| din | input | 32 | Shared bus for text words and key words |
| dout | output | 32 | Result word, high then low |
| dout_valid | output | 1 | Marks the two result words |
| key_req | output | 1 | One-cycle request for the next key |

## Verification
The vector table mixes encrypt and decrypt runs. These include all-zero text and keys, all-ones patterns, three equal keys and three distinct keys. The equal-key and zero cases show whether subkeys come out in the right round order and direction. The distinct-key cases show whether the keys are swapped between passes. A decrypt run on an encrypt result, with the keys reversed, must return the original text; this exposes any direction error that a shared mistake could hide. Directed runs cover a start and a mode flip arriving mid-run, a reset mid-run, and back-to-back starts. Every operation also checks the exact cycles of key_req and dout_valid, with garbage driven on din in all unsampled cycles.

// File: rtl/tdes_pkg.sv
package tdes_pkg;

    localparam int WORD_W   = 32;
    localparam int BLK_W    = 2 * WORD_W;
    localparam int HALF_W   = 28;
    localparam int CD_W     = 2 * HALF_W;
    localparam int NROUNDS  = 16;
    localparam int RND_W    = $clog2(NROUNDS);
    localparam int NPASSES  = 3;
    localparam int PASS_W   = $clog2(NPASSES + 1);
    localparam int LOAD_CYC = 3;
    localparam int LD_W     = $clog2(LOAD_CYC + 1);

    typedef enum logic [2:0] {
        S_IDLE,
        S_LOAD,
        S_RUN,
        S_OUT_HI,
        S_OUT_LO
    } ctl_state_e;

    // rotation amount for encrypt round idx
    function automatic logic [1:0] shift_amt(input logic [RND_W-1:0] idx);
        return (idx == 0 || idx == 1 || idx == 8 || idx == 15) ? 2'd1 : 2'd2;
    endfunction

    function automatic logic [HALF_W-1:0] rotl28(input logic [HALF_W-1:0] x,
                                                  input logic [1:0] n);
        unique case (n)
            2'd0:    return x;
            2'd1:    return {x[HALF_W-2:0], x[HALF_W-1]};
            default: return {x[HALF_W-3:0], x[HALF_W-1:HALF_W-2]};
        endcase
    endfunction

    function automatic logic [HALF_W-1:0] rotr28(input logic [HALF_W-1:0] x,
                                                  input logic [1:0] n);
        unique case (n)
            2'd0:    return x;
            2'd1:    return {x[0], x[HALF_W-1:1]};
            default: return {x[1:0], x[HALF_W-1:2]};
        endcase
    endfunction

    // keep the upper seven bits of every byte
    function automatic logic [CD_W-1:0] drop_parity(input logic [BLK_W-1:0] k);
        logic [CD_W-1:0] o;
        for (int b = 0; b < BLK_W / 8; b++) begin
            o[b*7 +: 7] = k[b*8+1 +: 7];
        end
        return o;
    endfunction

endpackage

// File: rtl/tdes_key_sched.sv
module tdes_key_sched
    import tdes_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic [BLK_W-1:0]    key_in,
    input  logic                step,
    input  logic                dec,
    input  logic [RND_W-1:0]    rnd,
    output logic [WORD_W-1:0]   subkey
);

    logic [HALF_W-1:0] c_q, d_q;
    logic [HALF_W-1:0] c_rot, d_rot;
    logic [1:0]        amt;
    logic [RND_W-1:0]  back_idx;

    // decrypt round j reuses the rotation state of encrypt round 15-j
    always_comb begin
        back_idx = RND_W'(5'd16 - {1'b0, rnd});
        if (dec) begin
            amt   = (rnd == 0) ? 2'd0 : shift_amt(back_idx);
            c_rot = rotr28(c_q, amt);
            d_rot = rotr28(d_q, amt);
        end else begin
            amt   = shift_amt(rnd);
            c_rot = rotl28(c_q, amt);
            d_rot = rotl28(d_q, amt);
        end
        subkey = {c_rot[27:12], d_rot[15:0]} ^ {d_rot[27:16], c_rot[11:0], 8'h00};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c_q <= '0;
            d_q <= '0;
        end else if (load) begin
            {c_q, d_q} <= drop_parity(key_in);
        end else if (step) begin
            c_q <= c_rot;
            d_q <= d_rot;
        end
    end

    // checker state: the sixteen encrypt rotations sum to one full turn
    logic [CD_W-1:0] chk_ref;
    logic [4:0]      chk_n;
    logic            chk_arm;

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_ref <= '0;
            chk_n   <= '0;
            chk_arm <= 1'b0;
        end else if (load) begin
            chk_ref <= drop_parity(key_in);
            chk_n   <= '0;
            chk_arm <= 1'b1;
        end else if (step && chk_n != 5'd31) begin
            chk_n <= chk_n + 5'd1;
        end
    end

    // R7: last encrypt round of a pass sees the freshly loaded halves again
    a_r7_enc_wrap: assert property (@(posedge clk) disable iff (rst)
        (step && !dec && chk_arm && chk_n == 5'd15) |-> ({c_rot, d_rot} == chk_ref));

endmodule

// File: rtl/tdes_round.sv
module tdes_round
    import tdes_pkg::*;
#(
    parameter logic [WORD_W-1:0] MIX_CONST = 32'h9E37_79B9,
    parameter int                ROT       = 3
)(
    input  logic [WORD_W-1:0] l_in,
    input  logic [WORD_W-1:0] r_in,
    input  logic [WORD_W-1:0] subkey,
    input  logic              last,
    output logic [WORD_W-1:0] l_out,
    output logic [WORD_W-1:0] r_out
);

    logic [WORD_W-1:0] t, mix;

    always_comb begin
        t   = r_in ^ subkey;
        mix = {t[WORD_W-1-ROT:0], t[WORD_W-1:WORD_W-ROT]} ^ (t + MIX_CONST);
        if (last) begin
            // closing round leaves the halves swapped
            l_out = l_in ^ mix;
            r_out = r_in;
        end else begin
            l_out = r_in;
            r_out = l_in ^ mix;
        end
    end

endmodule

// File: rtl/tdes_ede_ctrl.sv
module tdes_ede_ctrl
    import tdes_pkg::*;
#(
    parameter logic [WORD_W-1:0] MIX_CONST = 32'h9E37_79B9
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              decrypt,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] dout,
    output logic              dout_valid,
    output logic              key_req
);

    localparam logic [RND_W-1:0]  LAST_RND  = RND_W'(NROUNDS - 1);
    localparam logic [PASS_W-1:0] LAST_PASS = PASS_W'(NPASSES - 1);
    localparam logic [LD_W-1:0]   LAST_LD   = LD_W'(LOAD_CYC - 1);

    ctl_state_e st_q, st_d;

    logic [LD_W-1:0]   ld_q;
    logic [RND_W-1:0]  rnd_q;
    logic [PASS_W-1:0] pass_q;
    logic              dec_q;
    logic [WORD_W-1:0] l_q, r_q, khi_q;
    logic [BLK_W-1:0]  nk_q;

    logic              last_rnd, pass_dec, ks_load, ks_step;
    logic [BLK_W-1:0]  ks_key;
    logic [WORD_W-1:0] subkey, l_nxt, r_nxt;

    assign last_rnd = (rnd_q == LAST_RND);
    assign pass_dec = dec_q ^ (pass_q == PASS_W'(1));
    assign ks_step  = (st_q == S_RUN);
    assign ks_load  = (st_q == S_LOAD && ld_q == LAST_LD) ||
                      (st_q == S_RUN && last_rnd && pass_q != LAST_PASS);
    assign ks_key   = (st_q == S_LOAD) ? {khi_q, din} : nk_q;

    tdes_key_sched u_ks (
        .clk    (clk),
        .rst    (rst),
        .load   (ks_load),
        .key_in (ks_key),
        .step   (ks_step),
        .dec    (pass_dec),
        .rnd    (rnd_q),
        .subkey (subkey)
    );

    tdes_round #(.MIX_CONST(MIX_CONST)) u_rnd (
        .l_in   (l_q),
        .r_in   (r_q),
        .subkey (subkey),
        .last   (last_rnd),
        .l_out  (l_nxt),
        .r_out  (r_nxt)
    );

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE:   if (start) st_d = S_LOAD;
            S_LOAD:   if (ld_q == LAST_LD) st_d = S_RUN;
            S_RUN:    if (last_rnd && pass_q == LAST_PASS) st_d = S_OUT_HI;
            S_OUT_HI: st_d = S_OUT_LO;
            S_OUT_LO: st_d = S_IDLE;
            default:  st_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) st_q <= S_IDLE;
        else     st_q <= st_d;
    end

    // datapath and counters
    always_ff @(posedge clk) begin
        if (rst) begin
            ld_q   <= '0;
            rnd_q  <= '0;
            pass_q <= '0;
            dec_q  <= 1'b0;
            l_q    <= '0;
            r_q    <= '0;
            khi_q  <= '0;
            nk_q   <= '0;
        end else begin
            unique case (st_q)
                S_IDLE: begin
                    if (start) begin
                        l_q   <= din;
                        dec_q <= decrypt;
                        ld_q  <= '0;
                    end
                end
                S_LOAD: begin
                    ld_q <= ld_q + LD_W'(1);
                    if (ld_q == LD_W'(0)) r_q   <= din;
                    if (ld_q == LD_W'(1)) khi_q <= din;
                    if (ld_q == LAST_LD) begin
                        rnd_q  <= '0;
                        pass_q <= '0;
                    end
                end
                S_RUN: begin
                    l_q   <= l_nxt;
                    r_q   <= r_nxt;
                    rnd_q <= rnd_q + RND_W'(1);
                    if (last_rnd) pass_q <= pass_q + PASS_W'(1);
                    if (pass_q != LAST_PASS && rnd_q == RND_W'(1))
                        nk_q[BLK_W-1:WORD_W] <= din;
                    if (pass_q != LAST_PASS && rnd_q == RND_W'(2))
                        nk_q[WORD_W-1:0] <= din;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        dout       = '0;
        dout_valid = 1'b0;
        key_req    = 1'b0;
        unique case (st_q)
            S_RUN:    key_req = (rnd_q == '0) && (pass_q != LAST_PASS);
            S_OUT_HI: begin dout = l_q; dout_valid = 1'b1; end
            S_OUT_LO: begin dout = r_q; dout_valid = 1'b1; end
            default:  ;
        endcase
    end

    // R9: result words come as a pair and never as a longer burst
    a_r9_valid_pair: assert property (@(posedge clk) disable iff (rst)
        $rose(dout_valid) |=> dout_valid);
    a_r9_valid_end: assert property (@(posedge clk) disable iff (rst)
        (dout_valid && $past(dout_valid)) |=> !dout_valid);
    a_r9_quiet_bus: assert property (@(posedge clk) disable iff (rst)
        !dout_valid |-> (dout == '0));
    // R4: key request is a single-cycle pulse
    a_r4_req_pulse: assert property (@(posedge clk) disable iff (rst)
        key_req |=> !key_req);
    // R10: a busy controller never restarts its load sequence
    a_r10_no_restart: assert property (@(posedge clk) disable iff (rst)
        (st_q != S_IDLE) |=> !(st_q == S_LOAD && ld_q == '0));
    // R8: pass counter stays within the three passes while rounds run
    a_r8_pass_range: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_RUN) |-> (pass_q < PASS_W'(NPASSES)));

endmodule

// File: tb/sim_tdes_ede_ctrl.sv
`timescale 1ns/1ps
module sim_tdes_ede_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        decrypt = 1'b0;
    logic [31:0] din = '0;
    logic [31:0] dout;
    logic        dout_valid;
    logic        key_req;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    tdes_ede_ctrl u0 (
        .clk(clk), .rst(rst), .start(start), .decrypt(decrypt),
        .din(din), .dout(dout), .dout_valid(dout_valid), .key_req(key_req)
    );

    // ---------------- reference model from the requirements ----------------
    localparam int SH [16] = '{1,1,2,2,2,2,2,2,1,2,2,2,2,2,2,1};

    function automatic logic [55:0] m_pc1(input logic [63:0] k);
        logic [55:0] o;
        int idx;
        idx = 0;
        for (int i = 0; i < 64; i++) begin
            if (i % 8 != 0) begin
                o[idx] = k[i];
                idx++;
            end
        end
        return o;
    endfunction

    function automatic logic [27:0] m_rotl(input logic [27:0] x, input int n);
        logic [27:0] y;
        y = x;
        for (int i = 0; i < n; i++) y = {y[26:0], y[27]};
        return y;
    endfunction

    function automatic logic [31:0] m_f(input logic [31:0] r, input logic [31:0] k);
        logic [31:0] t;
        t = r ^ k;
        return {t[28:0], t[31:29]} ^ (t + 32'h9E37_79B9);
    endfunction

    function automatic logic [63:0] m_pass(input logic [63:0] blk,
                                           input logic [63:0] key, input bit dec);
        logic [55:0] cd;
        logic [27:0] c, d;
        logic [31:0] sk [16];
        logic [31:0] l, r, tmp;
        int cum;
        cd  = m_pc1(key);
        cum = 0;
        for (int j = 0; j < 16; j++) begin
            cum += SH[j];
            c = m_rotl(cd[55:28], cum % 28);
            d = m_rotl(cd[27:0],  cum % 28);
            sk[j] = {c[27:12], d[15:0]} ^ {d[27:16], c[11:0], 8'h00};
        end
        l = blk[63:32];
        r = blk[31:0];
        for (int j = 0; j < 16; j++) begin
            tmp = r;
            r   = l ^ m_f(r, dec ? sk[15-j] : sk[j]);
            l   = tmp;
        end
        return {r, l};
    endfunction

    function automatic logic [63:0] m_tdes(input logic [63:0] t, input logic [63:0] k1,
                                           input logic [63:0] k2, input logic [63:0] k3,
                                           input bit dec);
        return m_pass(m_pass(m_pass(t, k1, dec), k2, !dec), k3, dec);
    endfunction

    // ---------------- checking helpers ----------------
    task automatic check64(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %h exp %h", req, got, exp);
        end
    endtask

    task automatic check_int(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s got %0d exp %0d", req, got, exp);
        end
    endtask

    // One full operation: cycle c is the cycle before edge c+1.
    // poke=1 raises start with the opposite mode during the run (R10).
    task automatic run_op(input logic [63:0] t, input logic [63:0] k1,
                          input logic [63:0] k2, input logic [63:0] k3,
                          input bit dec, input bit poke,
                          output logic [63:0] res, output int tim_err);
        bit exp_kr, exp_v;
        tim_err = 0;
        res     = '0;
        for (int cyc = 0; cyc < 54; cyc++) begin
            @(negedge clk);
            exp_kr = (cyc == 4) || (cyc == 20);
            exp_v  = (cyc == 52) || (cyc == 53);
            if (key_req !== exp_kr)  tim_err++;
            if (dout_valid !== exp_v) tim_err++;
            if (!exp_v && dout !== 32'h0) tim_err++;
            if (cyc == 52) res[63:32] = dout;
            if (cyc == 53) res[31:0]  = dout;
            start   = (cyc == 0) || (poke && (cyc == 30 || cyc == 51));
            decrypt = (cyc == 0) ? dec : !dec;
            unique case (cyc)
                0:  din = t[63:32];
                1:  din = t[31:0];
                2:  din = k1[63:32];
                3:  din = k1[31:0];
                5:  din = k2[63:32];
                6:  din = k2[31:0];
                21: din = k3[63:32];
                22: din = k3[31:0];
                default: din = 32'hA5C3_0F00 ^ (32'(cyc) * 32'h0101_0101);
            endcase
        end
    endtask

    // ---------------- vectors: {decrypt, text, key1, key2, key3} ----------------
    localparam int NV = 5;
    localparam logic [256:0] VEC [NV] = '{
        {1'b0, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000,
               64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000},
        {1'b0, 64'h0123_4567_89AB_CDEF, 64'h1334_5779_9BBC_DFF1,
               64'h1334_5779_9BBC_DFF1, 64'h1334_5779_9BBC_DFF1},
        {1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF,
               64'h0000_0000_0000_0000, 64'hF0F0_F0F0_0F0F_0F0F},
        {1'b1, 64'h2F81_A8BF_3C6B_DFB4, 64'h0E32_9232_EA6D_0D73,
               64'h8000_0000_0000_0001, 64'h7CA1_1045_4A1A_6E57},
        {1'b1, 64'hDEAD_BEEF_0BAD_F00D, 64'h0001_0203_0405_0607,
               64'h0809_0A0B_0C0D_0E0F, 64'h1011_1213_1415_1617}
    };

    logic [63:0] res, res2, exp_v;
    int          terr;

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check64("R1 reset outputs", {dout, 31'h0, dout_valid, 31'h0, key_req},
                64'h0);
        rst = 1'b0;
        @(negedge clk);
        check64("R1 after release", {dout, 31'h0, dout_valid, 31'h0, key_req},
                64'h0);

        // vector walk: R2 R3 R4 R5 R6 R7 R8 R9
        for (int v = 0; v < NV; v++) begin
            run_op(VEC[v][255:192], VEC[v][191:128], VEC[v][127:64], VEC[v][63:0],
                   VEC[v][256], 1'b0, res, terr);
            exp_v = m_tdes(VEC[v][255:192], VEC[v][191:128], VEC[v][127:64],
                           VEC[v][63:0], VEC[v][256]);
            check64(VEC[v][256] ? "R6 R7 R8 decrypt vector" : "R5 R7 R8 encrypt vector",
                    res, exp_v);
            check_int("R4 R9 strobe timing", terr, 0);
        end

        // R6: round trip with reversed key order (back-to-back, R11)
        run_op(64'h4E6F_7720_6973_2074, 64'h0123_4567_89AB_CDEF,
               64'h2345_6789_ABCD_EF01, 64'h4567_89AB_CDEF_0123, 1'b0, 1'b0, res, terr);
        run_op(res, 64'h4567_89AB_CDEF_0123, 64'h2345_6789_ABCD_EF01,
               64'h0123_4567_89AB_CDEF, 1'b1, 1'b0, res2, terr);
        check64("R6 round trip", res2, 64'h4E6F_7720_6973_2074);
        check_int("R11 back-to-back timing", terr, 0);

        // R10 R3: start and opposite mode while busy are ignored
        run_op(64'h1122_3344_5566_7788, 64'hAAAA_5555_AAAA_5555,
               64'h0F1E_2D3C_4B5A_6978, 64'h8877_6655_4433_2211, 1'b0, 1'b1, res, terr);
        check64("R10 R3 busy start ignored", res,
                m_tdes(64'h1122_3344_5566_7788, 64'hAAAA_5555_AAAA_5555,
                       64'h0F1E_2D3C_4B5A_6978, 64'h8877_6655_4433_2211, 1'b0));
        check_int("R10 timing unchanged", terr, 0);

        // R1: reset mid-operation abandons the run
        @(negedge clk);
        start = 1'b1; din = 32'h1234_5678;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        terr = 0;
        for (int c = 0; c < 60; c++) begin
            @(negedge clk);
            if (dout_valid !== 1'b0 || key_req !== 1'b0) terr++;
        end
        check_int("R1 abort leaves outputs quiet", terr, 0);
        run_op(64'h0, 64'h0101_0101_0101_0101, 64'h0, 64'h0, 1'b1, 1'b0, res, terr);
        check64("R1 R6 run after abort", res,
                m_tdes(64'h0, 64'h0101_0101_0101_0101, 64'h0, 64'h0, 1'b1));

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog got timeout exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule